// File: doc/BRIEF.md
# Interleaved Rotating Shared Memory

This block is a shared word memory for sixteen clients. It is split into sixteen banks, and the low four bits of a long address pick the bank. The memory has no arbiter. A free-running commutator steps once per clock, and on each clock it ties every client to a different bank. Up to sixteen accesses therefore complete together, and two clients never meet on one bank.

A client raises a request and holds it steady. The request is acknowledged on the clock where the commutator connects that client to the bank its address needs. Writes carry per-byte enables. Reads return the full long one clock after the acknowledge, together with a valid flag. A client that walks through consecutive long addresses moves in step with the rotation, so it can transfer one long on every clock.

Top module: `rotating_hub_mem`

## Requirements
- R1: A long written at address A is returned by a later read of A. Address bits [3:0] select the bank and the remaining upper bits select the row inside that bank.
- R2: On each clock, client c is connected to bank (c + k) mod 16, where k is 0 on the first clock after reset and rises by one per clock. reqAck[c] is high exactly when reqValid[c] is high and reqAddr[c][3:0] equals that bank.
- R3: All sixteen clients can be acknowledged on the same clock when each one targets the bank connected to it, and no two acknowledged clients ever use the same bank.
- R4: For an acknowledged read, rspValid[c] goes high on the next clock and rspData[c] carries the stored long. rspValid stays low after writes and when there is no access.
- R5: On a write, byte enable bit i (reqBe[c][i]) updates only byte i, which is bits [8i+7:8i]. A write with all enables low leaves the long unchanged.
- R6: A held request is acknowledged after at most 15 clocks of waiting.
- R7: When a client follows an acknowledged access with a request to the next long address, that request is acknowledged on the very next clock.
- R8: While rst_n is low, no request is acknowledged and rspValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 16 | Per-client request present, held until acknowledged |
| reqWrite | input | 16 | Per-client write (1) or read (0) |
| reqAddr | input | 16x10 | Per-client long address |
| reqWdata | input | 16x32 | Per-client write data |
| reqBe | input | 16x4 | Per-client byte enables |
| reqAck | output | 16 | Request accepted on this clock |
| rspValid | output | 16 | Read data valid |
| rspData | output | 16x32 | Read data |

## Verification
The hardest cases to reach from the ports are two timing-sensitive situations. The first is all sixteen clients being granted on one clock. The second is a client streaming consecutive addresses with no gaps. Both depend on the rotation phase, which the ports do not show. The bench therefore tracks the phase from reset. It sets up a request for every client during reset, aimed at the bank that client will see on the first clock. It then launches a run of sequential reads. Random mixed traffic runs alongside, and the per-clock grant pattern and the worst-case wait are compared against the bench's own model.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int SEL_W = 4;
  localparam int NUM_PORTS = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             wr;
    logic [SEL_W-1:0] client;
  } bankStb_t;
endpackage

// File: rtl/hub_slot_ctrl.sv
module hub_slot_ctrl
  import hub_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 reqValid,
  input  logic [NUM_PORTS-1:0]                 reqWrite,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     reqAddr,
  output logic [NUM_PORTS-1:0]                 reqAck,
  output bankStb_t [NUM_PORTS-1:0]             bankStb,
  output logic [NUM_PORTS-1:0]                 rspValid,
  output logic [NUM_PORTS-1:0][SEL_W-1:0]      rspBank
);
  logic [SEL_W-1:0] rotCount;
  logic [NUM_PORTS-1:0][SEL_W-1:0] slotBank;

  always_ff @(posedge clk) begin
    if (!rst_n) rotCount <= '0;
    else        rotCount <= rotCount + 1'b1;
  end

  for (genvar c = 0; c < NUM_PORTS; c++) begin : g_client
    assign slotBank[c] = SEL_W'(c) + rotCount;
    assign reqAck[c] = rst_n & reqValid[c] & (reqAddr[c][SEL_W-1:0] == slotBank[c]);
  end

  for (genvar b = 0; b < NUM_PORTS; b++) begin : g_bank
    logic [SEL_W-1:0] owner;
    assign owner = SEL_W'(b) - rotCount;
    assign bankStb[b] = '{en: reqAck[owner], wr: reqWrite[owner], client: owner};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= '0;
      rspBank  <= '0;
    end else begin
      rspValid <= reqAck & ~reqWrite;
      rspBank  <= slotBank;
    end
  end

  // ---------------- assertions ----------------
  logic [NUM_PORTS-1:0] bankUse;
  always_comb begin
    bankUse = '0;
    for (int c = 0; c < NUM_PORTS; c++)
      if (reqAck[c]) bankUse[reqAddr[c][SEL_W-1:0]] = 1'b1;
  end

  // R3
  bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bankUse) == $countones(reqAck));

  for (genvar c = 0; c < NUM_PORTS; c++) begin : g_chk
    logic [SEL_W:0] waitCnt;
    always_ff @(posedge clk) begin
      if (!rst_n)                        waitCnt <= '0;
      else if (reqValid[c] && !reqAck[c]) waitCnt <= waitCnt + 1'b1;
      else                               waitCnt <= '0;
    end

    // R6
    slot_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waitCnt < (SEL_W+1)'(NUM_PORTS));

    // R7
    stream_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reqAck[c]) && reqValid[c] &&
       reqAddr[c] == ADDR_W'($past(reqAddr[c]) + 1'b1)) |-> reqAck[c]);
  end
endmodule

// File: rtl/hub_bank_array.sv
module hub_bank_array
  import hub_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int ROW_W = ADDR_W - SEL_W,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic                              clk,
  input  bankStb_t [NUM_PORTS-1:0]          bankStb,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqWdata,
  input  logic [NUM_PORTS-1:0][LANES-1:0]   reqBe,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]   rspBank,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rspData
);
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdReg;

  for (genvar b = 0; b < NUM_PORTS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] wdat;
    logic [LANES-1:0]  wbe;
    logic [DATA_W-1:0] rdQ;
    logic [SEL_W-1:0]  unusedLow;

    assign row       = reqAddr[bankStb[b].client][ADDR_W-1:SEL_W];
    assign unusedLow = reqAddr[bankStb[b].client][SEL_W-1:0];
    assign wdat      = reqWdata[bankStb[b].client];
    assign wbe       = reqBe[bankStb[b].client];

    always_ff @(posedge clk) begin
      if (bankStb[b].en) begin
        if (bankStb[b].wr) begin
          for (int l = 0; l < LANES; l++)
            if (wbe[l]) mem[row][l*8 +: 8] <= wdat[l*8 +: 8];
        end else begin
          rdQ <= mem[row];
        end
      end
    end
    assign rdReg[b] = rdQ;
  end

  for (genvar c = 0; c < NUM_PORTS; c++) begin : g_ret
    assign rspData[c] = rdReg[rspBank[c]];
  end
endmodule

// File: rtl/rotating_hub_mem.sv
module rotating_hub_mem
  import hub_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              reqValid,
  input  logic [NUM_PORTS-1:0]              reqWrite,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqWdata,
  input  logic [NUM_PORTS-1:0][LANES-1:0]   reqBe,
  output logic [NUM_PORTS-1:0]              reqAck,
  output logic [NUM_PORTS-1:0]              rspValid,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rspData
);
  bankStb_t [NUM_PORTS-1:0]        bankStb;
  logic [NUM_PORTS-1:0][SEL_W-1:0] rspBank;

  hub_slot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqAck(reqAck), .bankStb(bankStb),
    .rspValid(rspValid), .rspBank(rspBank)
  );

  hub_bank_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_banks (
    .clk(clk), .bankStb(bankStb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .rspBank(rspBank), .rspData(rspData)
  );

  for (genvar c = 0; c < NUM_PORTS; c++) begin : g_chk
    // R4
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rspValid[c] |-> ($past(reqAck[c]) && !$past(reqWrite[c])));
  end
endmodule

// File: tb/rotating_hub_mem_bench.sv
module rotating_hub_mem_bench;
  localparam int NP = 16;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]          qValid, qWrite, reqAck, rspValid;
  logic [NP-1:0][AW-1:0]  qAddr;
  logic [NP-1:0][DW-1:0]  qData, rspData;
  logic [NP-1:0][3:0]     qBe;

  rotating_hub_mem u_rotating_hub_mem (
    .clk(clk), .rst_n(rst_n), .reqValid(qValid), .reqWrite(qWrite),
    .reqAddr(qAddr), .reqWdata(qData), .reqBe(qBe),
    .reqAck(reqAck), .rspValid(rspValid), .rspData(rspData)
  );

  int nChecks = 0, nFails = 0, mc = 0, cyc = 0, mode = 0;
  logic          curValid [NP];
  logic          curWrite [NP];
  logic [AW-1:0] curAddr  [NP];
  logic [31:0]   curData  [NP];
  logic [3:0]    curBe    [NP];
  int            waitCyc  [NP];
  int            fillK    [NP];
  logic          ackedNow [NP];
  logic          expRsp   [NP];
  logic [31:0]   expData  [NP];
  logic [31:0]   lastRsp  [NP];
  logic [31:0]   model    [MW];
  bit checkAll = 0;
  int byteOp = 0, seqN = 0, seqFirst = -1, seqLast = -1;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  task automatic newReq(int c, bit w, logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
    curValid[c] = 1'b1; curWrite[c] = w; curAddr[c] = a;
    curData[c] = d; curBe[c] = be; waitCyc[c] = 0;
  endtask

  task automatic drive();
    for (int c = 0; c < NP; c++) begin
      qValid[c] = curValid[c]; qWrite[c] = curWrite[c]; qAddr[c] = curAddr[c];
      qData[c] = curData[c]; qBe[c] = curBe[c];
    end
  endtask

  task automatic generate_next();
    for (int c = 0; c < NP; c++) begin
      if (mode == 1 && ackedNow[c] && fillK[c] < 7) begin
        fillK[c]++;
        newReq(c, 1'b1, AW'(fillK[c]*16 + c), 32'hC0DE0000 | 32'(fillK[c]*16 + c), 4'hF);
      end
      if (mode == 2 && !curValid[c] && ($urandom % 2) == 1)
        newReq(c, ($urandom % 2) == 1, AW'($urandom % MW), $urandom, 4'($urandom % 16));
    end
    if (mode == 3 && !curValid[2] && byteOp < 4) begin
      case (byteOp)
        0: newReq(2, 1'b1, 10'h040, 32'h11223344, 4'hF);
        1: newReq(2, 1'b1, 10'h040, 32'hAABBCCDD, 4'b0101);
        2: newReq(2, 1'b1, 10'h040, 32'hFFFFFFFF, 4'b0000);
        default: newReq(2, 1'b0, 10'h040, 32'h0, 4'h0);
      endcase
      byteOp++;
    end
    if (mode == 4 && !curValid[5] && seqN < 20) begin
      newReq(5, 1'b0, AW'(32 + seqN), 32'h0, 4'h0);
      seqN++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int c = 0; c < NP; c++) begin
      check(rspValid[c] == expRsp[c], "R4", $sformatf("rspValid client %0d", c),
            32'(rspValid[c]), 32'(expRsp[c]));
      if (expRsp[c] && rspValid[c]) begin
        check(rspData[c] === expData[c], "R1", $sformatf("read data client %0d", c),
              rspData[c], expData[c]);
        lastRsp[c] = rspData[c];
      end
      expRsp[c] = 1'b0;
    end
    if (checkAll)
      check($countones(reqAck) == NP, "R3", "all clients granted together",
            32'($countones(reqAck)), 32'(NP));
    for (int c = 0; c < NP; c++) begin
      bit e;
      e = curValid[c] && (curAddr[c][3:0] == 4'((c + mc) % 16));
      ackedNow[c] = 1'b0;
      check(reqAck[c] == e, "R2", $sformatf("ack client %0d", c), 32'(reqAck[c]), 32'(e));
      if (e) begin
        check(waitCyc[c] <= 15, "R6", $sformatf("wait client %0d", c), 32'(waitCyc[c]), 32'd15);
        if (curWrite[c])
          model[curAddr[c][6:0]] = merge(model[curAddr[c][6:0]], curData[c], curBe[c]);
        else begin
          expRsp[c] = 1'b1;
          expData[c] = model[curAddr[c][6:0]];
        end
        if (mode == 4 && c == 5) begin
          if (seqFirst < 0) seqFirst = cyc;
          seqLast = cyc;
        end
        curValid[c] = 1'b0;
        ackedNow[c] = 1'b1;
      end else if (curValid[c]) waitCyc[c]++;
    end
    @(posedge clk);
    mc = (mc + 1) % 16;
    #1;
    generate_next();
    drive();
  endtask

  function automatic bit busy();
    for (int c = 0; c < NP; c++) if (curValid[c] || expRsp[c]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < MW; i++) model[i] = '0;
    for (int c = 0; c < NP; c++) begin
      curValid[c] = 0; expRsp[c] = 0; fillK[c] = 0; ackedNow[c] = 0; lastRsp[c] = '0;
      // R3 setup: client c writes row 0 of bank c, which it meets on the first clock
      newReq(c, 1'b1, AW'(c), 32'hC0DE0000 | 32'(c), 4'hF);
    end
    drive();
    repeat (3) begin
      @(negedge clk);
      check(reqAck == '0, "R8", "ack in reset", 32'(reqAck), 32'h0);
      check(rspValid == '0, "R8", "rspValid in reset", 32'(rspValid), 32'h0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1; mc = 0;
    mode = 1; checkAll = 1;
    step();
    checkAll = 0;
    for (int i = 0; i < 400 && (busy() || fillK[0] < 7); i++) step();

    mode = 3;
    generate_next(); drive();
    for (int i = 0; i < 200 && (busy() || byteOp < 4); i++) step();
    check(lastRsp[2] == 32'h11BB33DD, "R5", "byte-enable merge", lastRsp[2], 32'h11BB33DD);

    mode = 4;
    generate_next(); drive();
    for (int i = 0; i < 200 && (busy() || seqN < 20); i++) step();
    check(seqLast - seqFirst == 19, "R7", "sequential stream span", 32'(seqLast - seqFirst), 32'd19);

    mode = 2;
    for (int i = 0; i < 3000; i++) step();
    mode = 0;
    for (int i = 0; i < 100 && busy(); i++) step();
    step();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule